// File: doc/BRIEF.md
# BT.656 Embedded Timing Decoder

This block accepts an 8-bit multiplexed component video stream. It takes one byte on each rising edge of a clock that runs at twice the pixel rate. It watches the stream for the four-byte timing reference codes that mark the end and the start of active video. From those codes alone it derives registered blanking, horizontal sync, vertical sync and field outputs. No external sync pin takes part, and the three sync signals are only ever driven as outputs. It also produces a pixel-rate clock at half the input clock frequency.

Inside active video, the incoming bytes alternate Cb, Y, Cr, Y. The block steers them onto separate chroma and luma outputs. A side-band overlay word is sampled on every luma byte, but each overlay word refers to the luma sample taken a fixed number of pixels earlier. The block delays luma by that many samples, so that each luma output appears together with the overlay word that belongs to it.

Top module: `bt656_timing_decoder`

## Requirements
- R1: While the synchronous active-low reset is held, blankOut, hsyncOut, vsyncOut, fieldOut, pixClkOut and yValid are all 0.
- R2: A timing code is the byte run FF, 00, 00 followed by a status byte. In the status byte, bit 7 is 1, bit 6 is the field flag F, bit 5 is the vertical flag V and bit 4 is H, where H=1 marks the end of active video and H=0 marks its start. After the edge that samples a valid status byte, blankOut equals H OR V.
- R3: The low four bits of the status byte must equal {V^H, F^H, F^V, F^V^H}, most significant bit first, and bit 7 must be 1. A status byte that fails this check changes no output and does not start active video.
- R4: After the edge that samples a valid status byte, fieldOut equals F.
- R5: hsyncOut rises at the edge that samples each valid code with H=1 and stays high for exactly HSYNC_W clock cycles.
- R6: vsyncOut rises at a valid H=1 code that has V=1 when the previous valid code had V=0. It falls at the VSYNC_LINES-th following H=1 code, so it stays high for VSYNC_LINES lines.
- R7: pixClkOut starts at 0 after reset and inverts on every clock edge, giving half the input clock frequency.
- R8: After a valid code with H=0 and V=0, bytes are taken in the order Cb, Y, Cr, Y. cbOut and crOut load on their own bytes and hold their value otherwise. An FF byte ends active video, and that FF is not taken as chroma.
- R9: On each luma byte, yOut loads the luma sampled OVL_LAG luma slots earlier and ovlOut loads the overlay word sampled now. For one cycle, yValid is 1 exactly when that delayed luma came from active video.
- R10: A valid code with H=0 and V=1 leaves blankOut at 1 and loads no chroma.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk2x | input | 1 | Clock at twice the pixel rate; every rising edge samples one byte |
| rst_n | input | 1 | Synchronous reset, active low |
| dataIn | input | 8 | Multiplexed video byte stream |
| ovlIn | input | OVL_W | Overlay side-band word, sampled on luma bytes |
| blankOut | output | 1 | Blanking, high outside active video |
| hsyncOut | output | 1 | Horizontal sync pulse |
| vsyncOut | output | 1 | Vertical sync pulse |
| fieldOut | output | 1 | Current field flag |
| pixClkOut | output | 1 | Pixel-rate clock |
| cbOut | output | 8 | Last Cb sample from active video |
| crOut | output | 8 | Last Cr sample from active video |
| yOut | output | 8 | Luma delayed to line up with ovlOut |
| ovlOut | output | OVL_W | Overlay word paired with yOut |
| yValid | output | 1 | One-cycle marker for an active-video luma output |

## Verification
The bench builds the block with HSYNC_W=6 and VSYNC_LINES=2, and leaves OVL_LAG at 3 and OVL_W at 5. A short sync width lets a single blanking run after one code show both the rising and the falling edge of hsyncOut. A two-line vertical pulse lets three consecutive end codes show vsyncOut rise, hold across one line and fall. With the default lag, a line of eight luma samples shows the unfilled delay slots and the aligned luma and overlay pairs.

// File: rtl/bt656_pkg.sv
package bt656_pkg;

  typedef enum logic [1:0] {
    SRCH    = 2'd0,
    SEEN_FF = 2'd1,
    SEEN_Z1 = 2'd2,
    SEEN_Z2 = 2'd3
  } codeState_t;

  typedef struct packed {
    logic capCb;
    logic capY;
    logic capCr;
    logic lumaAct;
  } bt656Strobe_t;

  function automatic logic [3:0] protBits(input logic f, input logic v, input logic h);
    return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

endpackage

// File: rtl/bt656_ctrl.sv
module bt656_ctrl
  import bt656_pkg::*;
#(
  parameter int HSYNC_W     = 16,
  parameter int VSYNC_LINES = 3
) (
  input  logic         clk2x,
  input  logic         rst_n,
  input  logic [7:0]   dataIn,
  output bt656Strobe_t stb,
  output logic         blankOut,
  output logic         hsyncOut,
  output logic         vsyncOut,
  output logic         fieldOut,
  output logic         pixClkOut
);
  localparam int HS_CW = $clog2(HSYNC_W + 1);
  localparam int VS_CW = $clog2(VSYNC_LINES + 1);

  codeState_t state, stateNxt;
  logic [1:0] phase;
  logic       active;
  logic       vFlagQ;
  logic [HS_CW-1:0] hsCnt;
  logic [VS_CW-1:0] vsCnt;

  logic isFF, isZero, statusOk, codeHit, fBit, vBit, hBit;

  assign isFF     = (dataIn == 8'hFF);
  assign isZero   = (dataIn == 8'h00);
  assign fBit     = dataIn[6];
  assign vBit     = dataIn[5];
  assign hBit     = dataIn[4];
  assign statusOk = dataIn[7] && (dataIn[3:0] == protBits(fBit, vBit, hBit));
  assign codeHit  = (state == SEEN_Z2) && statusOk;

  // code search
  always_comb begin
    stateNxt = SRCH;
    case (state)
      SRCH:    stateNxt = isFF ? SEEN_FF : SRCH;
      SEEN_FF: stateNxt = isZero ? SEEN_Z1 : (isFF ? SEEN_FF : SRCH);
      SEEN_Z1: stateNxt = isZero ? SEEN_Z2 : (isFF ? SEEN_FF : SRCH);
      SEEN_Z2: stateNxt = isFF ? SEEN_FF : SRCH;
      default: stateNxt = SRCH;
    endcase
  end

  always_ff @(posedge clk2x) begin
    if (!rst_n) state <= SRCH;
    else        state <= stateNxt;
  end

  // byte steering strobes
  always_comb begin
    stb.lumaAct = active && !isFF;
    stb.capY    = phase[0];
    stb.capCb   = active && !isFF && (phase == 2'd0);
    stb.capCr   = active && !isFF && (phase == 2'd2);
  end

  always_ff @(posedge clk2x) begin
    if (!rst_n) begin
      phase  <= 2'd0;
      active <= 1'b0;
    end else if (codeHit) begin
      phase  <= 2'd0;
      active <= !hBit && !vBit;
    end else begin
      phase  <= phase + 2'd1;
      if (isFF) active <= 1'b0;
    end
  end

  // timing flags
  always_ff @(posedge clk2x) begin
    if (!rst_n) begin
      blankOut <= 1'b0;
      fieldOut <= 1'b0;
      vFlagQ   <= 1'b0;
    end else if (codeHit) begin
      blankOut <= hBit || vBit;
      fieldOut <= fBit;
      vFlagQ   <= vBit;
    end
  end

  always_ff @(posedge clk2x) begin
    if (!rst_n) begin
      hsyncOut <= 1'b0;
      hsCnt    <= '0;
    end else if (codeHit && hBit) begin
      hsyncOut <= 1'b1;
      hsCnt    <= HS_CW'(HSYNC_W - 1);
    end else if (hsyncOut) begin
      if (hsCnt == '0) hsyncOut <= 1'b0;
      else             hsCnt    <= hsCnt - 1'b1;
    end
  end

  always_ff @(posedge clk2x) begin
    if (!rst_n) begin
      vsyncOut <= 1'b0;
      vsCnt    <= '0;
    end else if (codeHit && hBit) begin
      if (vBit && !vFlagQ) begin
        vsyncOut <= 1'b1;
        vsCnt    <= VS_CW'(VSYNC_LINES - 1);
      end else if (vsyncOut) begin
        if (vsCnt == '0) vsyncOut <= 1'b0;
        else             vsCnt    <= vsCnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk2x) begin
    if (!rst_n) pixClkOut <= 1'b0;
    else        pixClkOut <= !pixClkOut;
  end

  // R2: blanking moves only on a status byte
  a_r2_blank_on_code: assert property (@(posedge clk2x) disable iff (!rst_n)
    $past(rst_n) && !$stable(blankOut) |-> $past(state == SEEN_Z2));
  // R4: field moves only on a status byte
  a_r4_field_on_code: assert property (@(posedge clk2x) disable iff (!rst_n)
    $past(rst_n) && !$stable(fieldOut) |-> $past(state == SEEN_Z2));
  // R5: a horizontal pulse starts inside blanking
  a_r5_hs_in_blank: assert property (@(posedge clk2x) disable iff (!rst_n)
    $rose(hsyncOut) |-> blankOut);
  // R6: a vertical pulse starts together with a horizontal one
  a_r6_vs_with_hs: assert property (@(posedge clk2x) disable iff (!rst_n)
    $rose(vsyncOut) |-> hsyncOut && blankOut);

endmodule

// File: rtl/bt656_datapath.sv
module bt656_datapath
  import bt656_pkg::*;
#(
  parameter int OVL_W   = 5,
  parameter int OVL_LAG = 3
) (
  input  logic             clk2x,
  input  logic             rst_n,
  input  logic [7:0]       dataIn,
  input  logic [OVL_W-1:0] ovlIn,
  input  bt656Strobe_t     stb,
  output logic [7:0]       cbOut,
  output logic [7:0]       crOut,
  output logic [7:0]       yOut,
  output logic [OVL_W-1:0] ovlOut,
  output logic             yValid
);
  localparam int LAST = OVL_LAG - 1;

  logic [7:0] yPipe   [OVL_LAG];
  logic       actPipe [OVL_LAG];

  for (genvar g = 0; g < OVL_LAG; g++) begin : g_stage
    always_ff @(posedge clk2x) begin
      if (!rst_n) begin
        yPipe[g]   <= 8'h00;
        actPipe[g] <= 1'b0;
      end else if (stb.capY) begin
        if (g == 0) begin
          yPipe[g]   <= dataIn;
          actPipe[g] <= stb.lumaAct;
        end else begin
          yPipe[g]   <= yPipe[(g == 0) ? 0 : g - 1];
          actPipe[g] <= actPipe[(g == 0) ? 0 : g - 1];
        end
      end
    end
  end

  always_ff @(posedge clk2x) begin
    if (!rst_n) begin
      yOut   <= 8'h00;
      ovlOut <= '0;
      yValid <= 1'b0;
    end else if (stb.capY) begin
      yOut   <= yPipe[LAST];
      ovlOut <= ovlIn;
      yValid <= actPipe[LAST];
    end else begin
      yValid <= 1'b0;
    end
  end

  always_ff @(posedge clk2x) begin
    if (!rst_n) begin
      cbOut <= 8'h00;
      crOut <= 8'h00;
    end else begin
      if (stb.capCb) cbOut <= dataIn;
      if (stb.capCr) crOut <= dataIn;
    end
  end

  // R8: chroma outputs change only on their own strobe
  a_r8_cb_on_strobe: assert property (@(posedge clk2x) disable iff (!rst_n)
    $past(rst_n) && !$stable(cbOut) |-> $past(stb.capCb));
  a_r8_cr_on_strobe: assert property (@(posedge clk2x) disable iff (!rst_n)
    $past(rst_n) && !$stable(crOut) |-> $past(stb.capCr));
  // R9: a valid luma marker only follows a luma slot
  a_r9_valid_on_luma: assert property (@(posedge clk2x) disable iff (!rst_n)
    yValid |-> $past(stb.capY));

endmodule

// File: rtl/bt656_timing_decoder.sv
module bt656_timing_decoder
  import bt656_pkg::*;
#(
  parameter int OVL_W       = 5,
  parameter int OVL_LAG     = 3,
  parameter int HSYNC_W     = 16,
  parameter int VSYNC_LINES = 3
) (
  input  logic             clk2x,
  input  logic             rst_n,
  input  logic [7:0]       dataIn,
  input  logic [OVL_W-1:0] ovlIn,
  output logic             blankOut,
  output logic             hsyncOut,
  output logic             vsyncOut,
  output logic             fieldOut,
  output logic             pixClkOut,
  output logic [7:0]       cbOut,
  output logic [7:0]       crOut,
  output logic [7:0]       yOut,
  output logic [OVL_W-1:0] ovlOut,
  output logic             yValid
);
  bt656Strobe_t stb;

  bt656_ctrl #(
    .HSYNC_W(HSYNC_W),
    .VSYNC_LINES(VSYNC_LINES)
  ) ctrl_i (
    .clk2x(clk2x),
    .rst_n(rst_n),
    .dataIn(dataIn),
    .stb(stb),
    .blankOut(blankOut),
    .hsyncOut(hsyncOut),
    .vsyncOut(vsyncOut),
    .fieldOut(fieldOut),
    .pixClkOut(pixClkOut)
  );

  bt656_datapath #(
    .OVL_W(OVL_W),
    .OVL_LAG(OVL_LAG)
  ) dp_i (
    .clk2x(clk2x),
    .rst_n(rst_n),
    .dataIn(dataIn),
    .ovlIn(ovlIn),
    .stb(stb),
    .cbOut(cbOut),
    .crOut(crOut),
    .yOut(yOut),
    .ovlOut(ovlOut),
    .yValid(yValid)
  );

endmodule

// File: tb/bt656_timing_decoder_tb_top.sv
module bt656_timing_decoder_tb_top;
  localparam int OVL_W = 5;
  localparam int LAG   = 3;
  localparam int HSW   = 6;
  localparam int VSL   = 2;

  logic clk2x = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic [OVL_W-1:0] ovlIn = '0;
  logic blankOut, hsyncOut, vsyncOut, fieldOut, pixClkOut, yValid;
  logic [7:0] cbOut, crOut, yOut;
  logic [OVL_W-1:0] ovlOut;

  int total = 0;
  int bad   = 0;

  always #2.5 clk2x = ~clk2x;

  bt656_timing_decoder #(
    .OVL_W(OVL_W), .OVL_LAG(LAG), .HSYNC_W(HSW), .VSYNC_LINES(VSL)
  ) dut_i (
    .clk2x(clk2x), .rst_n(rst_n), .dataIn(dataIn), .ovlIn(ovlIn),
    .blankOut(blankOut), .hsyncOut(hsyncOut), .vsyncOut(vsyncOut),
    .fieldOut(fieldOut), .pixClkOut(pixClkOut), .cbOut(cbOut), .crOut(crOut),
    .yOut(yOut), .ovlOut(ovlOut), .yValid(yValid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] status(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  task automatic putByte(input logic [7:0] b, input logic [OVL_W-1:0] ov);
    @(negedge clk2x);
    dataIn = b;
    ovlIn  = ov;
    @(posedge clk2x);
    #1;
  endtask

  task automatic putCodeRaw(input logic [7:0] st);
    putByte(8'hFF, '0);
    putByte(8'h00, '0);
    putByte(8'h00, '0);
    putByte(st, '0);
  endtask

  task automatic putBlankQuad();
    putByte(8'h80, '0);
    putByte(8'h10, '0);
    putByte(8'h80, '0);
    putByte(8'h10, '0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk2x);
    #1;
    chk("R1 blank", blankOut, 0);
    chk("R1 hsync", hsyncOut, 0);
    chk("R1 vsync", vsyncOut, 0);
    chk("R1 field", fieldOut, 0);
    chk("R1 pixclk", pixClkOut, 0);
    chk("R1 yvalid", yValid, 0);
    @(negedge clk2x);
    rst_n = 1'b1;
  endtask

  task automatic t_pixclk();
    logic prev;
    @(posedge clk2x);
    #1;
    chk("R7 first toggle", pixClkOut, 1);
    prev = pixClkOut;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk2x);
      #1;
      chk("R7 toggle", pixClkOut, !prev);
      prev = pixClkOut;
    end
  endtask

  task automatic t_eav_hsync();
    int highs;
    putCodeRaw(status(1'b0, 1'b0, 1'b1));
    chk("R2 blank after end code", blankOut, 1);
    chk("R5 hsync rise", hsyncOut, 1);
    chk("R4 field zero", fieldOut, 0);
    highs = 1;
    for (int q = 0; q < 2; q++) begin
      for (int b = 0; b < 4; b++) begin
        putByte((b % 2 == 0) ? 8'h80 : 8'h10, '0);
        if (hsyncOut) highs++;
      end
    end
    chk("R5 hsync width", highs, HSW);
    chk("R5 hsync ended", hsyncOut, 0);
  endtask

  task automatic t_active();
    putCodeRaw(status(1'b0, 1'b0, 1'b0));
    chk("R2 blank low after start code", blankOut, 0);
    for (int j = 0; j < 4; j++) begin
      for (int k = 0; k < 2; k++) begin
        int i;
        i = 2 * j + k;
        if (k == 0) begin
          putByte(8'h40 + 8'(j), '0);
          chk("R8 cb load", cbOut, 8'h40 + 8'(j));
        end else begin
          putByte(8'hC0 + 8'(j), '0);
          chk("R8 cr load", crOut, 8'hC0 + 8'(j));
        end
        putByte(8'h20 + 8'(i), OVL_W'(i - LAG));
        if (i < LAG) begin
          chk("R9 unfilled slot", yValid, 0);
        end else begin
          chk("R9 yvalid", yValid, 1);
          chk("R9 delayed luma", yOut, 8'h20 + 8'(i - LAG));
          chk("R9 overlay pair", ovlOut, OVL_W'(i - LAG));
        end
      end
    end
    putByte(8'hFF, '0);
    chk("R8 FF not chroma", cbOut, 8'h43);
    putByte(8'h00, '0);
    putByte(8'h00, '0);
    putByte(status(1'b0, 1'b0, 1'b1), '0);
    chk("R2 blank at line end", blankOut, 1);
    putBlankQuad();
  endtask

  task automatic t_badcode();
    logic [7:0] cbKeep;
    cbKeep = cbOut;
    putCodeRaw(status(1'b1, 1'b0, 1'b0) ^ 8'h01);
    chk("R3 bad code keeps blank", blankOut, 1);
    chk("R3 bad code keeps field", fieldOut, 0);
    putByte(8'h55, '0);
    chk("R3 no active after bad code", cbOut, cbKeep);
    putByte(8'h10, '0);
    putByte(8'h80, '0);
    putByte(8'h10, '0);
    putCodeRaw(status(1'b0, 1'b0, 1'b1) & 8'h7F);
    chk("R3 bit7 clear ignored", hsyncOut, 0);
    putBlankQuad();
  endtask

  task automatic t_field();
    putCodeRaw(status(1'b1, 1'b0, 1'b1));
    chk("R4 field one", fieldOut, 1);
    putBlankQuad();
    putCodeRaw(status(1'b0, 1'b0, 1'b1));
    chk("R4 field back to zero", fieldOut, 0);
    putBlankQuad();
    putBlankQuad();
  endtask

  task automatic t_vsync();
    logic [7:0] cbKeep;
    cbKeep = cbOut;
    chk("R6 idle", vsyncOut, 0);
    putCodeRaw(status(1'b0, 1'b1, 1'b1));
    chk("R6 vsync rise", vsyncOut, 1);
    putBlankQuad();
    putCodeRaw(status(1'b0, 1'b1, 1'b0));
    chk("R10 blank kept in vertical blank", blankOut, 1);
    putByte(8'h77, '0);
    chk("R10 no chroma in vertical blank", cbOut, cbKeep);
    putByte(8'h10, '0);
    putByte(8'h80, '0);
    putByte(8'h10, '0);
    putCodeRaw(status(1'b0, 1'b1, 1'b1));
    chk("R6 vsync held second line", vsyncOut, 1);
    putBlankQuad();
    putCodeRaw(status(1'b0, 1'b1, 1'b1));
    chk("R6 vsync fall", vsyncOut, 0);
    putBlankQuad();
  endtask

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_pixclk();
    t_eav_hsync();
    t_active();
    t_badcode();
    t_field();
    t_vsync();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule